// File: doc/BRIEF.md
# Radio Transceiver Register Access Engine

This block is a serial-bus master that carries out one register read or one register write on an external radio transceiver per request. The transceiver exposes two register spaces: a short space reached with a 6-bit address and a long space reached with a 10-bit address. A requester presents the operation, the address class, the address and, for writes, a data byte. The engine converts these into the transceiver's command bytes, frames the access with an active-low chip select, shifts the bytes out in SPI mode 0, and raises a one-cycle completion strobe. For reads it returns the byte the transceiver drives back.

The two address classes use different headers. A short access uses a single header byte. A long access uses a two-byte header, and its read/write flag sits in a different position from the short one. The serial clock is divided down from the system clock. A fixed idle guard interval comes before every byte and follows the final one, and another guard interval follows the release of chip select. A new request is taken only while the engine is idle.

Top module: `rspi_engine`

## Requirements
- R1: During and straight after reset, chip select is high, the serial clock is low, busy and done are low, and the read data is 0x00.
- R2: A request is accepted on a clock edge where req_valid is high and busy is low, and busy is high from the next cycle on. A request raised while busy is high is ignored: it starts no further chip-select frame and changes no byte on the bus.
- R3: The bus runs in SPI mode 0 with the MSB first. The serial clock is low whenever chip select is high. MOSI changes only while the clock is low. MISO is sampled on the rising clock edge.
- R4: A short access sends a first byte with bit 7 = 0, bits 6:1 = the 6-bit address, and bit 0 = 1 for a write or 0 for a read.
- R5: A long access sends two header bytes. The first has bit 7 = 1 and bits 6:0 = address bits 9:3. The second has bits 7:5 = address bits 2:0, bit 4 = 1 for a write or 0 for a read, and bits 3:0 = 0.
- R6: On a write, the data byte is sent as the last byte of the frame, right after the header.
- R7: On a read, the last byte sent is 0xFF. The byte received during that transfer appears on rd_data when done is high.
- R8: Chip select stays low for the whole access, which carries exactly 2 bytes for a short access and 3 bytes for a long one. Chip select is never low while busy is low.
- R9: At least GAP idle system cycles pass between the fall of chip select and the first rising clock edge, between the last falling edge of one byte and the next rising edge, between the last falling edge and the rise of chip select, and between the rise of chip select and done. GAP = CLK_HZ/1000 * GAP_NS / 1e6, with a minimum of 1.
- R10: done is high for exactly one cycle, and busy is low in that cycle. rd_data changes only in a done cycle, and only after a read.
- R11: Each high and each low phase of the serial clock lasts exactly CLK_HZ / (2*SCK_HZ) system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = 10-bit long address space, 0 = 6-bit short space |
| req_addr | input | 10 | Register address (bits 5:0 used for short accesses) |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Byte returned by the last read |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_miso | input | 1 | Serial data from the transceiver |
| spi_csn | output | 1 | Chip select, active low |

## Verification
A wrong byte index or a bad header build shows up within the first byte of the frame: the transceiver model decodes every header byte and compares it against the encoding expected for that address class. A phase counter or bit counter that drifts shows up on the very next serial-clock edge as a half period of the wrong length, or as the wrong byte count when chip select rises. A sequencer that skips a guard state shows up as a short gap at the next chip-select or first-bit edge. A sequencer that fails to return to idle never produces done, so the access hangs. A capture register that updates at the wrong time shows up as rd_data moving outside a done cycle, or carrying the wrong byte after a read.

// File: rtl/rspi_pkg.sv
package rspi_pkg;

    localparam int BYTE_W    = 8;
    localparam int SHORT_AW  = 6;
    localparam int LONG_AW   = 10;
    localparam int MAX_BYTES = 3;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef logic [BYTE_W-1:0] octet_t;

    localparam octet_t FILL_BYTE = 8'hFF;

    // one access as handed over by the requester
    typedef struct packed {
        logic                  is_write;
        logic                  is_long;
        logic [LONG_AW-1:0]    addr;
        octet_t                wdata;
    } acc_req_t;

    // bytes of one chip-select frame, slot 0 goes out first
    typedef struct packed {
        octet_t [MAX_BYTES-1:0] bytes;
        logic   [CNT_W-1:0]     count;
    } frame_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SHIFT,
        PH_SETTLE,
        PH_TAIL
    } phase_e;

    function automatic octet_t short_head(input logic [SHORT_AW-1:0] a, input logic wr);
        return {1'b0, a, wr};
    endfunction

    function automatic octet_t long_head_hi(input logic [LONG_AW-1:0] a);
        return {1'b1, a[LONG_AW-1:3]};
    endfunction

    function automatic octet_t long_head_lo(input logic [LONG_AW-1:0] a, input logic wr);
        return {a[2:0], wr, 4'b0000};
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/rspi_cmd_build.sv
module rspi_cmd_build
    import rspi_pkg::*;
(
    input  acc_req_t req,
    output frame_t   frame
);

    octet_t payload;

    assign payload = req.is_write ? req.wdata : FILL_BYTE;

    always_comb begin
        frame = '0;
        if (req.is_long) begin
            frame.bytes[0] = long_head_hi(req.addr);
            frame.bytes[1] = long_head_lo(req.addr, req.is_write);
            frame.bytes[2] = payload;
            frame.count    = CNT_W'(3);
        end else begin
            frame.bytes[0] = short_head(req.addr[SHORT_AW-1:0], req.is_write);
            frame.bytes[1] = payload;
            frame.count    = CNT_W'(2);
        end
    end

endmodule

// File: rtl/rspi_shifter.sv
module rspi_shifter
    import rspi_pkg::*;
#(
    parameter int unsigned HALF_CYC = 50
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  octet_t tx_byte,
    input  logic   miso,
    output logic   sck,
    output logic   mosi,
    output logic   byte_done,
    output octet_t rx_byte
);

    localparam int PW = $clog2(HALF_CYC + 1);
    localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

    logic          active;
    logic [PW-1:0] ph;
    logic [2:0]    bitn;
    octet_t        shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            ph        <= '0;
            bitn      <= '0;
            shreg     <= '0;
            sck       <= 1'b0;
            mosi      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                ph     <= '0;
                bitn   <= '0;
                shreg  <= tx_byte;
                mosi   <= tx_byte[BYTE_W-1];
                sck    <= 1'b0;
            end else if (active) begin
                if (ph == PH_LAST) begin
                    ph <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[BYTE_W-2:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            mosi  <= shreg[BYTE_W-2];
                        end
                    end
                end else begin
                    ph <= ph + PW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rspi_seq.sv
module rspi_seq
    import rspi_pkg::*;
#(
    parameter int unsigned GAP_CYC = 50
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  acc_req_t req_in,
    input  frame_t   frame,
    input  logic     sh_done,
    input  octet_t   sh_rx,
    output acc_req_t held,
    output logic     busy,
    output logic     done,
    output octet_t   rd_data,
    output logic     csn,
    output logic     sh_start,
    output octet_t   sh_tx
);

    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

    phase_e             ph;
    logic [GW-1:0]      gcnt;
    logic [CNT_W-1:0]   idx;
    octet_t             last_rx;
    logic               gap_end;
    logic               last_slot;

    assign busy      = (ph != PH_IDLE);
    assign gap_end   = (gcnt == GAP_LAST);
    assign last_slot = (idx == frame.count - CNT_W'(1));
    assign sh_tx     = frame.bytes[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            gcnt     <= '0;
            idx      <= '0;
            held     <= '0;
            last_rx  <= '0;
            rd_data  <= '0;
            csn      <= 1'b1;
            done     <= 1'b0;
            sh_start <= 1'b0;
        end else begin
            done     <= 1'b0;
            sh_start <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        held <= req_in;
                        idx  <= '0;
                        gcnt <= '0;
                        csn  <= 1'b0;
                        ph   <= PH_LEAD;
                    end
                end
                PH_LEAD: begin
                    if (gap_end) begin
                        gcnt     <= '0;
                        sh_start <= 1'b1;
                        ph       <= PH_SHIFT;
                    end else begin
                        gcnt <= gcnt + GW'(1);
                    end
                end
                PH_SHIFT: begin
                    if (sh_done) begin
                        last_rx <= sh_rx;
                        gcnt    <= '0;
                        ph      <= PH_SETTLE;
                    end
                end
                PH_SETTLE: begin
                    if (gap_end) begin
                        gcnt <= '0;
                        if (last_slot) begin
                            csn <= 1'b1;
                            ph  <= PH_TAIL;
                        end else begin
                            idx      <= idx + CNT_W'(1);
                            sh_start <= 1'b1;
                            ph       <= PH_SHIFT;
                        end
                    end else begin
                        gcnt <= gcnt + GW'(1);
                    end
                end
                PH_TAIL: begin
                    if (gap_end) begin
                        gcnt <= '0;
                        done <= 1'b1;
                        if (!held.is_write) begin
                            rd_data <= last_rx;
                        end
                        ph <= PH_IDLE;
                    end else begin
                        gcnt <= gcnt + GW'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rspi_engine.sv
module rspi_engine
    import rspi_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned SCK_HZ = 500_000,
    parameter int unsigned GAP_NS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_long,
    input  logic [9:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_csn
);

    localparam int unsigned HALF_CYC = at_least_one(CLK_HZ / (2 * SCK_HZ));
    localparam int unsigned GAP_CYC  = at_least_one((CLK_HZ / 1000) * GAP_NS / 1_000_000);

    acc_req_t req_in;
    acc_req_t held;
    frame_t   frame;
    logic     sh_start;
    logic     sh_done;
    octet_t   sh_tx;
    octet_t   sh_rx;

    assign req_in = '{is_write: req_write, is_long: req_long, addr: req_addr, wdata: req_wdata};

    rspi_cmd_build u_build (
        .req   (held),
        .frame (frame)
    );

    rspi_seq #(.GAP_CYC(GAP_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .frame     (frame),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .held      (held),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .csn       (spi_csn),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx)
    );

    rspi_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

endmodule

// File: rtl/rspi_engine_chk.sv
module rspi_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic [7:0] rd_data,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic       spi_csn
);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sck) else $error("sck high outside frame"); // R3

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi)) else $error("mosi moved while sck high"); // R3

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy) else $error("request not taken"); // R2

    AST_CSN_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        !spi_csn |-> busy) else $error("chip select low while idle"); // R8

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && spi_csn)) else $error("done while frame open"); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_data)) else $error("rd_data moved outside done"); // R10

endmodule

bind rspi_engine rspi_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_csn   (spi_csn)
);

// File: tb/sim_rspi_engine.sv
module sim_rspi_engine;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned T_CLK_HZ = 8_000_000;
    localparam int unsigned T_SCK_HZ = 1_000_000;
    localparam int unsigned T_GAP_NS = 1000;
    localparam int HALF = T_CLK_HZ / (2 * T_SCK_HZ);
    localparam int GAP  = (T_CLK_HZ / 1000) * T_GAP_NS / 1_000_000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_long = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, spi_sck, spi_mosi, spi_csn;
    logic [7:0] rd_data;
    logic       spi_miso = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rspi_engine #(.CLK_HZ(T_CLK_HZ), .SCK_HZ(T_SCK_HZ), .GAP_NS(T_GAP_NS)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_csn(spi_csn)
    );

    // transceiver model and timing monitor, sampled away from the active edge
    logic [7:0] sl_resp = 8'h00;
    logic [7:0] sl_sh = '0;
    logic [7:0] sl_bytes [0:7];
    int sl_bits = 0, sl_nbytes = 0, sl_obit = 0, sl_txn = 0;
    int ecnt = 1000, drun = 0;
    bit bad_half = 0, bad_gap = 0, bad_mode = 0, bad_done = 0;
    logic prev_sck = 1'b0, prev_csn = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sck && spi_csn) bad_mode = 1;
            if (done) begin
                drun = drun + 1;
                if (drun > 1 || busy) bad_done = 1;
            end else drun = 0;
            if (spi_csn != prev_csn) begin
                if (ecnt < GAP) bad_gap = 1;
                if (!spi_csn) begin
                    sl_bits = 0; sl_nbytes = 0; sl_obit = 0;
                    spi_miso = sl_resp[7];
                end else begin
                    sl_txn = sl_txn + 1;
                end
                ecnt = 1;
            end else if (spi_sck != prev_sck) begin
                if (spi_sck) begin
                    if (sl_bits % 8 == 0) begin
                        if (ecnt < GAP + HALF) bad_gap = 1;
                    end else if (ecnt != HALF) bad_half = 1;
                    sl_sh = {sl_sh[6:0], spi_mosi};
                    sl_bits = sl_bits + 1;
                    if (sl_bits % 8 == 0) begin
                        if (sl_nbytes < 8) sl_bytes[sl_nbytes] = sl_sh;
                        sl_nbytes = sl_nbytes + 1;
                    end
                end else begin
                    if (ecnt != HALF) bad_half = 1;
                    sl_obit = sl_obit + 1;
                    spi_miso = sl_resp[7 - (sl_obit % 8)];
                end
                ecnt = 1;
            end else begin
                ecnt = ecnt + 1;
            end
            prev_sck = spi_sck;
            prev_csn = spi_csn;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // issues one access and checks frame, timing and returned data
    task automatic run_access(input bit wr, input bit lg, input logic [9:0] a,
                              input logic [7:0] d, input logic [7:0] resp);
        logic [7:0] exp [0:2];
        int n;
        int txn0;
        logic [7:0] rd_before;
        rd_before = rd_data;
        txn0 = sl_txn;
        sl_resp = resp;
        if (lg) begin
            exp[0] = {1'b1, a[9:3]};
            exp[1] = {a[2:0], wr, 4'b0000};
            exp[2] = wr ? d : 8'hFF;
            n = 3;
        end else begin
            exp[0] = {1'b0, a[5:0], wr};
            exp[1] = wr ? d : 8'hFF;
            exp[2] = 8'h00;
            n = 2;
        end
        @(negedge clk);
        req_valid = 1; req_write = wr; req_long = lg; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(busy === 1'b1, "R2 busy after accept", 32'(busy), 1);
        while (done !== 1'b1) @(negedge clk);
        chk(sl_txn == txn0 + 1, "R8 one frame per access", sl_txn - txn0, 1);
        chk(sl_nbytes == n, "R8 bytes in frame", sl_nbytes, n);
        chk(sl_bytes[0] === exp[0], lg ? "R5 long header byte0" : "R4 short header", sl_bytes[0], exp[0]);
        if (lg) chk(sl_bytes[1] === exp[1], "R5 long header byte1", sl_bytes[1], exp[1]);
        if (wr) chk(sl_bytes[n-1] === exp[n-1], "R6 write data byte", sl_bytes[n-1], exp[n-1]);
        else    chk(sl_bytes[n-1] === 8'hFF, "R7 read fill byte", sl_bytes[n-1], 8'hFF);
        if (wr) chk(rd_data === rd_before, "R10 rd_data kept on write", rd_data, rd_before);
        else    chk(rd_data === resp, "R7 read data returned", rd_data, resp);
        @(negedge clk);
        chk(!done && !busy, "R10 single done pulse", {done, busy}, 0);
        chk(!bad_half, "R11 sck half period", bad_half, 0);
        chk(!bad_gap, "R9 guard gaps", bad_gap, 0);
        chk(!bad_mode, "R3 sck low outside frame", bad_mode, 0);
        chk(!bad_done, "R10 done shape", bad_done, 0);
    endtask

    task automatic t_reset();
        chk(spi_csn === 1'b1, "R1 csn after reset", spi_csn, 1);
        chk(spi_sck === 1'b0, "R1 sck after reset", spi_sck, 0);
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
        chk(rd_data === 8'h00, "R1 rd_data after reset", rd_data, 0);
    endtask

    task automatic t_busy_ignore();
        int txn0;
        txn0 = sl_txn;
        sl_resp = 8'h96;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_long = 0; req_addr = 10'h015; req_wdata = 8'h00;
        @(negedge clk);
        req_write = 1; req_long = 1; req_addr = 10'h2C7; req_wdata = 8'hEE;
        repeat (30) @(negedge clk);
        req_valid = 0;
        while (done !== 1'b1) @(negedge clk);
        chk(sl_nbytes == 2, "R2 ignored request bytes", sl_nbytes, 2);
        chk(sl_bytes[0] === {1'b0, 6'h15, 1'b0}, "R2 first request kept", sl_bytes[0], {1'b0, 6'h15, 1'b0});
        chk(rd_data === 8'h96, "R2 read of first request", rd_data, 8'h96);
        repeat (4 * GAP) @(negedge clk);
        chk(sl_txn == txn0 + 1 && spi_csn === 1'b1, "R2 no extra frame", sl_txn - txn0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual=hang expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        run_access(1, 0, 10'h02A, 8'hA5, 8'h00);   // short write
        run_access(0, 0, 10'h03F, 8'h00, 8'h3C);   // short read, top address
        run_access(1, 0, 10'h000, 8'h00, 8'hFF);   // short write, zero
        run_access(1, 1, 10'h3FF, 8'h5A, 8'h00);   // long write, top address
        run_access(0, 1, 10'h201, 8'h00, 8'hC3);   // long read
        run_access(0, 1, 10'h000, 8'h00, 8'h81);   // long read, zero address
        run_access(1, 1, 10'h0F6, 8'h01, 8'h7E);   // write keeps read data
        t_busy_ignore();
        run_access(0, 0, 10'h011, 8'h00, 8'h00);   // read returning zero
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule